// File: doc/BRIEF.md
# Tunable Quadrature NCO

The block is a numerically controlled oscillator that sits at the end of a digital phase-locked loop. It keeps its phase in fractions of a cycle and adds a step on every sample strobe. The step has two parts: a fixed nominal frequency word, and a correction. The correction is the loop filter's signed tuning value scaled down by 1/4096. On each strobe the block also presents a cosine (in-phase) sample and a sine (quadrature) sample. Both come from the phase held before that strobe.

The sine and cosine come from a quarter-wave magnitude table. The table's contents are computed at elaboration by a constant function. Only the top bits of the phase address the table: the two highest bits pick the quadrant and the bits below them pick the entry. The raw phase is also brought out. A phase detector or a second loop can use it.

Top module: `nco_quad_top`

## Requirements
- R1: A synchronous active-high `rst` sets `phase_out`, `i_out` and `q_out` to zero at the next rising clock edge.
- R2: When `sample_en` is low, `phase_out`, `i_out` and `q_out` keep their values, whatever `freq_word` and `tune_in` do.
- R3: On each clock edge with `sample_en` high, `phase_out` becomes (old phase + `freq_word` + floor(`tune_in` / 4096)) mod 2^20. The phase LSB weighs 2^-20 cycle. `tune_in` is a 24-bit two's-complement value with the same LSB weight.
- R4: The tuning correction rounds toward minus infinity, through an arithmetic shift. For example, `tune_in` = -1 lowers the step by one LSB, and `tune_in` = -4097 lowers it by two LSBs.
- R5: The `i_out` and `q_out` presented after an enabled edge are computed from the value `phase_out` had before that edge, which gives one sample of latency.
- R6: Let p be bits 19..10 of that phase. Then `i_out` = round(2048·cos(2πp/1024)) and `q_out` = round(2048·sin(2πp/1024)). Both are 12-bit two's complement, and halves round away from zero.
- R7: A peak of +1.0 gives code 2047 and a peak of -1.0 gives -2047. Code -2048 never appears.
- R8: The phase wraps modulo one cycle when stepping both up and down.
- R9: Phase bits 9..0 take part in accumulation but have no effect on `i_out` or `q_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Sample strobe; the phase advances when it is high |
| freq_word | input | 20 | Nominal phase step per sample, unsigned, in 2^-20 cycle |
| tune_in | input | 24 | Signed tuning value from the loop filter, in 2^-20 units |
| i_out | output | 12 | Cosine sample, signed |
| q_out | output | 12 | Sine sample, signed |
| phase_out | output | 20 | Accumulated phase, in 2^-20 cycle |

## Verification
Every result lands one edge after the strobe that causes it. The new phase appears at that edge, and the cosine and sine that appear at the same edge belong to the phase before it. The bench drives its inputs on the falling edge. It checks on the next falling edge, half a period after the single register stage has loaded. Its model computes the expected cosine and sine from the phase it held before applying the step, so the one-sample lag is modelled rather than absorbed. Sweeps cover every one of the 1024 table positions, a slow crawl through the low bits, negative and positive tuning, and stretches with the strobe low.

// File: rtl/nco_pkg.sv
package nco_pkg;

   // Rounded, saturated magnitude of sin(pi/2 * k / 2^aw) at amplitude 2^(ow-1).
   function automatic int quarter_entry(input int k, input int aw, input int ow);
      real x;
      real term;
      real acc;
      real amp;
      int  r;
      int  lim;
      x    = 1.5707963267948966 * real'(k) / real'(1 << aw);
      term = x;
      acc  = x;
      for (int n = 1; n < 16; n++) begin
         term = -term * x * x / real'((2 * n) * (2 * n + 1));
         acc  = acc + term;
      end
      amp = real'(1 << (ow - 1));
      lim = (1 << (ow - 1)) - 1;
      r   = $rtoi(acc * amp + 0.5);
      if (r > lim) r = lim;
      if (r < 0) r = 0;
      return r;
   endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
   parameter int PHASE_W    = 20,
   parameter int TUNE_W     = 24,
   parameter int TUNE_SHIFT = 12
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     step_en,
   input  logic [PHASE_W-1:0]       freq_word,
   input  logic signed [TUNE_W-1:0] tune_in,
   output logic [PHASE_W-1:0]       phase
);
   localparam int EXT_W = (TUNE_W > PHASE_W) ? TUNE_W : PHASE_W;

   generate
      if (TUNE_SHIFT >= EXT_W) begin : g_bad_shift
         $error("nco_phase_acc: TUNE_SHIFT must be below the extended tune width");
      end
   endgenerate

   logic signed [EXT_W-1:0] tune_ext;
   logic [PHASE_W-1:0]      tune_step;
   logic [PHASE_W-1:0]      inc;

   assign tune_ext  = EXT_W'(tune_in);
   assign tune_step = PHASE_W'(tune_ext >>> TUNE_SHIFT);
   assign inc       = freq_word + tune_step;

   always_ff @(posedge clk) begin
      if (rst)          phase <= '0;
      else if (step_en) phase <= phase + inc;
   end

   // R3: zero nominal word and a tune below one shifted LSB leave the phase unchanged
   assert_zero_step_R3: assert property (@(posedge clk) disable iff (rst)
      (step_en && freq_word == '0 && tune_in >= 0 &&
       tune_in < TUNE_W'(1 << TUNE_SHIFT)) |=> $stable(phase));

   // R4: a tune of -1 with zero word moves the phase back by one LSB
   assert_floor_neg_R4: assert property (@(posedge clk) disable iff (rst)
      (step_en && freq_word == '0 && tune_in == -1) |=>
      (phase == $past(phase) - PHASE_W'(1)));
endmodule

// File: rtl/nco_wave_lookup.sv
module nco_wave_lookup #(
   parameter int ADDR_W = 8,
   parameter int OUT_W  = 12
) (
   input  logic [ADDR_W+1:0]       addr,
   output logic signed [OUT_W-1:0] value
);
   localparam int N = 1 << ADDR_W;

   generate
      if (OUT_W < 4 || OUT_W > 30) begin : g_bad_out
         $error("nco_wave_lookup: OUT_W out of supported range");
      end
   endgenerate

   logic [OUT_W-1:0] tbl [0:N];

   generate
      for (genvar k = 0; k <= N; k++) begin : g_tbl
         localparam int ENTRY = nco_pkg::quarter_entry(k, ADDR_W, OUT_W);
         assign tbl[k] = OUT_W'(ENTRY);
      end
   endgenerate

   logic [1:0]        quad;
   logic [ADDR_W:0]   offs;
   logic [ADDR_W:0]   idx;
   logic [OUT_W-1:0]  mag;

   assign quad  = addr[ADDR_W+1:ADDR_W];
   assign offs  = {1'b0, addr[ADDR_W-1:0]};
   assign idx   = quad[0] ? ((ADDR_W+1)'(N) - offs) : offs;
   assign mag   = tbl[idx];
   assign value = quad[1] ? -$signed(mag) : $signed(mag);

   // R7: the folded value never reaches the most negative code
   always_comb begin
      assert_no_min_code_R7: assert (value != {1'b1, {(OUT_W-1){1'b0}}});
   end
endmodule

// File: rtl/nco_quad_top.sv
module nco_quad_top #(
   parameter int PHASE_W    = 20,
   parameter int TUNE_W     = 24,
   parameter int OUT_W      = 12,
   parameter int ADDR_W     = 8,
   parameter int TUNE_SHIFT = 12
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     sample_en,
   input  logic [PHASE_W-1:0]       freq_word,
   input  logic signed [TUNE_W-1:0] tune_in,
   output logic signed [OUT_W-1:0]  i_out,
   output logic signed [OUT_W-1:0]  q_out,
   output logic [PHASE_W-1:0]       phase_out
);
   localparam int TBL_AW = ADDR_W + 2;
   localparam logic signed [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};

   generate
      if (TBL_AW > PHASE_W) begin : g_bad_addr
         $error("nco_quad_top: table address wider than phase");
      end
   endgenerate

   logic [PHASE_W-1:0] phase;
   logic [TBL_AW-1:0]  tbl_addr;
   logic signed [OUT_W-1:0] wave [0:1];  // [0] sine, [1] cosine

   nco_phase_acc #(
      .PHASE_W(PHASE_W), .TUNE_W(TUNE_W), .TUNE_SHIFT(TUNE_SHIFT)
   ) acc_i (
      .clk(clk), .rst(rst), .step_en(sample_en),
      .freq_word(freq_word), .tune_in(tune_in), .phase(phase)
   );

   assign tbl_addr = phase[PHASE_W-1 -: TBL_AW];

   generate
      for (genvar g = 0; g < 2; g++) begin : g_wave
         logic [TBL_AW-1:0] addr_g;
         assign addr_g = tbl_addr + (TBL_AW'(g) << ADDR_W);
         nco_wave_lookup #(.ADDR_W(ADDR_W), .OUT_W(OUT_W)) lut_i (
            .addr(addr_g), .value(wave[g])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         i_out <= '0;
         q_out <= '0;
      end else if (sample_en) begin
         i_out <= wave[1];
         q_out <= wave[0];
      end
   end

   assign phase_out = phase;

   // R1: outputs are cleared on the edge after reset
   assert_reset_clear_R1: assert property (@(posedge clk)
      $past(rst) |-> (phase_out == '0 && i_out == '0 && q_out == '0));

   // R2: all outputs hold while the strobe is low
   assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !sample_en |=> ($stable(phase_out) && $stable(i_out) && $stable(q_out)));

   // R5: a strobe at phase zero yields full-scale cosine and zero sine one edge later
   assert_origin_R5: assert property (@(posedge clk) disable iff (rst)
      (sample_en && phase_out == '0) |=> (i_out == POS_MAX && q_out == '0));
endmodule

// File: tb/nco_quad_top_tb_top.sv
module nco_quad_top_tb_top;
   logic               clk = 0;
   logic               rst = 1;
   logic               sample_en = 0;
   logic [19:0]        freq_word = '0;
   logic signed [23:0] tune_in = '0;
   logic signed [11:0] i_out, q_out;
   logic [19:0]        phase_out;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done = 0;
   longint ph = 0;
   int  ei = 0;
   int  eq = 0;

   always #5 clk = ~clk;

   nco_quad_top dut_i (
      .clk(clk), .rst(rst), .sample_en(sample_en), .freq_word(freq_word),
      .tune_in(tune_in), .i_out(i_out), .q_out(q_out), .phase_out(phase_out)
   );

   function automatic int ref_wave(longint p, bit use_cos);
      real th;
      real v;
      int  r;
      th = 2.0 * 3.141592653589793 * real'(p >> 10) / 1024.0;
      v  = (use_cos ? $cos(th) : $sin(th)) * 2048.0;
      r  = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
      if (r > 2047) r = 2047;
      if (r < -2047) r = -2047;
      return r;
   endfunction

   task automatic chk(string tag, longint act, longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Called at a falling edge; checks one falling edge later.
   task automatic step(bit en, longint fw, int tune, string tag);
      longint t;
      sample_en = en;
      freq_word = fw[19:0];
      tune_in   = tune[23:0];
      if (en) begin
         ei = ref_wave(ph, 1);
         eq = ref_wave(ph, 0);
         t  = longint'(tune_in) >>> 12;
         ph = (((ph + fw + t) % 1048576) + 1048576) % 1048576;
      end
      @(negedge clk);
      chk({tag, " i"}, i_out, ei);
      chk({tag, " q"}, q_out, eq);
      chk({tag, " phase"}, phase_out, ph);
   endtask

   task automatic do_reset();
      rst = 1;
      sample_en = 1;
      @(negedge clk);
      @(negedge clk);
      rst = 0;
      ph = 0; ei = 0; eq = 0;
      chk("R1 reset i", i_out, 0);
      chk("R1 reset q", q_out, 0);
      chk("R1 reset phase", phase_out, 0);
   endtask

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
         end
      end
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      do_reset();

      // R5/R7: first strobe at phase zero shows full-scale cosine
      step(1, 20'h80000, 0, "R5 origin");
      chk("R7 peak pos", i_out, 2047);
      step(1, 20'h80000, 0, "R7 half");
      chk("R7 peak neg", i_out, -2047);

      // R6/R8: one table step per sample, every position and a wrap
      do_reset();
      for (int k = 0; k < 1030; k++) step(1, 1024, 0, "R6 sweep");

      // R9: crawl through the low bits
      do_reset();
      for (int k = 0; k < 2100; k++) step(1, 1, 0, "R9 low bits");

      // R3: positive tuning on a nominal word
      for (int k = 0; k < 300; k++) step(1, 5000, 12345 + k * 97, "R3 tune pos");

      // R4: negative tuning rounds down
      step(1, 100, -1, "R4 minus one");
      step(1, 100, -4097, "R4 minus 4097");
      for (int k = 0; k < 200; k++) step(1, 300, -(k * 611), "R4 tune neg");

      // R8: stepping backward across zero
      do_reset();
      for (int k = 0; k < 300; k++) step(1, 0, -40960 * 7, "R8 backward wrap");

      // R2: strobe low while inputs move
      for (int k = 0; k < 40; k++) step(0, $urandom, int'($urandom) >>> 8, "R2 hold");
      step(1, 777, 0, "R2 resume");

      // R3/R6: random words and tunes with occasional gaps
      for (int k = 0; k < 4000; k++) begin
         bit en;
         en = ($urandom % 5) != 0;
         step(en, $urandom, int'($urandom) >>> 8, "R3 random");
      end

      // R1: reset in mid-run
      step(1, 1234, 0, "R1 pre");
      do_reset();

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule